// File: doc/BRIEF.md
# Raster Frame Writeback Address Generator

This block turns one composed display frame into a stream of word write requests, so that the frame lands in memory as a raster image. Before a frame, the host presents a destination start address, a line stride in bytes, a packed size word and a pixel-size select. It then pulses `start`. The block checks the setup. It walks every pixel of every line, left to right and top to bottom. For each pixel it offers one request, which carries a word-aligned byte address and a 4-bit byte strobe, on a valid/ready port. A line counter reports how many lines have had every write accepted.

The controller is a three-state machine. `ST_IDLE` waits for `start`. On the GO transition, taken when `start` arrives with a legal setup, it moves to `ST_EMIT`. On the REJECT transition, taken when `start` arrives with an illegal setup, it stays in `ST_IDLE` and raises the sticky error flag. `ST_EMIT` offers requests and stays there after every accepted write except the last. On the FINAL transition, when the last pixel of the last line is accepted, it moves to `ST_DONE`. `ST_DONE` lasts one cycle and takes the RETIRE transition back to `ST_IDLE`.

Top module: `wb_raster_agen`

## Requirements
- R1: During and right after reset, `req_valid`, `busy`, `done` and `err` are 0 and `lines_done` is 0.
- R2: A start is legal when all of the following hold: the start address has bits 1:0 equal to 0, the stride has bits 3:0 equal to 0, and the size fields are in range (R9). A legal start in `ST_IDLE` makes `req_valid` 1 in the following cycle. That first request carries the start address.
- R3: The size word holds the pixels per line in bits 15:0 and the line count in bits 31:16. A frame yields exactly width × height accepted requests, after which `req_valid` falls.
- R4: When `cfg_pix16` is 0, pixels are 4 bytes. The request for pixel x of line n has address base + n·stride + 4x and strobe 4'b1111.
- R5: When `cfg_pix16` is 1, pixels are 2 bytes. The byte offset is base + n·stride + 2x, and the request address is that offset with bits 1:0 cleared. The strobe is 4'b0011 when bit 1 of the offset is 0, and 4'b1100 when it is 1.
- R6: While `req_valid` is 1 and `req_ready` is 0, the request stays valid and its address and strobe do not change.
- R7: `lines_done` becomes 0 in the cycle after a legal start. It rises by one in the cycle after the last write of each line is accepted, and it ends the frame equal to the height.
- R8: A start whose address bits 1:0 or stride bits 3:0 are not all 0 sets `err`. It produces no request and leaves `lines_done` unchanged.
- R9: A start with width 0, height 0, height above 4088, or width above 1920 (4-byte pixels) or 3840 (2-byte pixels) is rejected in the same way as R8. The limits themselves are accepted.
- R10: `err` stays set until the next legal start, which clears it.
- R11: `done` is 1 for exactly the one cycle after the final write is accepted. `busy` is 0 from the cycle after that.
- R12: A `start` pulse, or a change of the setup inputs, while `busy` is 1 has no effect on the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame start request |
| cfg_base | input | 32 | Destination start byte address |
| cfg_pitch | input | 16 | Line stride in bytes |
| cfg_dim | input | 32 | Height in 31:16, width in 15:0 |
| cfg_pix16 | input | 1 | 1 selects 2-byte pixels, 0 selects 4-byte pixels |
| req_valid | output | 1 | Write request offered |
| req_ready | input | 1 | Write request accepted this cycle |
| req_addr | output | 32 | Word-aligned byte address |
| req_strb | output | 4 | Byte strobe |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle frame completion pulse |
| err | output | 1 | Sticky setup error |
| lines_done | output | 16 | Lines fully written |

## Verification
The first request is due one cycle after the edge that samples a legal start. A line count step is due one cycle after the accepting edge of a line's last write. `done` is due one cycle after the final accept, and an error appears one cycle after a rejected start. The bench drives inputs and samples outputs on the falling clock edge. It therefore always reads the state produced by the previous rising edge, and it compares each sample against counters it advances only when it has itself offered ready to a valid request.

// File: rtl/wbag_pkg.sv
package wbag_pkg;
    localparam int STRB_W = 4;
    localparam logic [STRB_W-1:0] STRB_FULL = 4'b1111;
    localparam logic [STRB_W-1:0] STRB_LOW  = 4'b0011;
    localparam logic [STRB_W-1:0] STRB_HIGH = 4'b1100;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EMIT = 2'd1,
        ST_DONE = 2'd2
    } wbag_state_e;
endpackage

// File: rtl/wbag_cfg_check.sv
module wbag_cfg_check #(
    parameter int DIM_W        = 16,
    parameter int MAX_LINES    = 4088,
    parameter int MAX_PIX_WIDE = 1920
) (
    input  logic [1:0]         base_lo,
    input  logic [3:0]         pitch_lo,
    input  logic [2*DIM_W-1:0] dim,
    input  logic               pix16,
    output logic [DIM_W-1:0]   width,
    output logic [DIM_W-1:0]   height,
    output logic               cfg_ok
);
    localparam logic [DIM_W-1:0] LIM_H   = DIM_W'(MAX_LINES);
    localparam logic [DIM_W-1:0] LIM_W32 = DIM_W'(MAX_PIX_WIDE);
    localparam logic [DIM_W-1:0] LIM_W16 = DIM_W'(2 * MAX_PIX_WIDE);

    logic align_ok;
    logic dims_ok;

    always_comb begin
        width    = dim[DIM_W-1:0];
        height   = dim[2*DIM_W-1:DIM_W];
        align_ok = (base_lo == 2'b00) && (pitch_lo == 4'b0000);
        dims_ok  = (width != '0) && (height != '0) && (height <= LIM_H) &&
                   (width <= (pix16 ? LIM_W16 : LIM_W32));
        cfg_ok   = align_ok && dims_ok;
    end
endmodule

// File: rtl/wbag_walker.sv
module wbag_walker
    import wbag_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int PITCH_W = 16,
    parameter int DIM_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                adv,
    input  logic [ADDR_W-3:0]   base_word,
    input  logic [PITCH_W-3:0]  pitch_word,
    input  logic [DIM_W-1:0]    width,
    input  logic [DIM_W-1:0]    height,
    input  logic                pix16,
    output logic [ADDR_W-1:0]   addr,
    output logic [STRB_W-1:0]   strb,
    output logic                last_px,
    output logic                last_line,
    output logic [DIM_W-1:0]    lines_done
);
    logic [ADDR_W-3:0]  line_word;
    logic [DIM_W:0]     px_half;
    logic [DIM_W-1:0]   x_cnt;
    logic [DIM_W-1:0]   wid_q;
    logic [DIM_W-1:0]   hgt_q;
    logic [PITCH_W-3:0] pitch_q;
    logic               p16_q;
    logic [DIM_W:0]     step;
    logic [ADDR_W-3:0]  word_addr;

    always_comb begin
        step      = p16_q ? (DIM_W+1)'(1) : (DIM_W+1)'(2);
        word_addr = line_word + (ADDR_W-2)'(px_half[DIM_W:1]);
        addr      = {word_addr, 2'b00};
        strb      = !p16_q ? STRB_FULL : (px_half[0] ? STRB_HIGH : STRB_LOW);
        last_px   = (x_cnt == wid_q - 1'b1);
        last_line = (lines_done == hgt_q - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_word  <= '0;
            px_half    <= '0;
            x_cnt      <= '0;
            lines_done <= '0;
            wid_q      <= '0;
            hgt_q      <= '0;
            pitch_q    <= '0;
            p16_q      <= 1'b0;
        end else if (load) begin
            line_word  <= base_word;
            px_half    <= '0;
            x_cnt      <= '0;
            lines_done <= '0;
            wid_q      <= width;
            hgt_q      <= height;
            pitch_q    <= pitch_word;
            p16_q      <= pix16;
        end else if (adv) begin
            if (last_px) begin
                line_word  <= line_word + (ADDR_W-2)'(pitch_q);
                px_half    <= '0;
                x_cnt      <= '0;
                lines_done <= lines_done + 1'b1;
            end else begin
                px_half <= px_half + step;
                x_cnt   <= x_cnt + 1'b1;
            end
        end
    end

    // R7: the line count only steps by one or returns to zero
    p_prog_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lines_done != $past(lines_done)) |->
            (lines_done == $past(lines_done) + DIM_W'(1)) || (lines_done == '0));

    // R7: the line count never passes the latched height
    p_prog_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |-> (lines_done <= hgt_q));
endmodule

// File: rtl/wb_raster_agen.sv
module wb_raster_agen
    import wbag_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int PITCH_W      = 16,
    parameter int DIM_W        = 16,
    parameter int MAX_LINES    = 4088,
    parameter int MAX_PIX_WIDE = 1920
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ADDR_W-1:0]    cfg_base,
    input  logic [PITCH_W-1:0]   cfg_pitch,
    input  logic [2*DIM_W-1:0]   cfg_dim,
    input  logic                 cfg_pix16,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic [ADDR_W-1:0]    req_addr,
    output logic [STRB_W-1:0]    req_strb,
    output logic                 busy,
    output logic                 done,
    output logic                 err,
    output logic [DIM_W-1:0]     lines_done
);
    wbag_state_e state_q, state_d;

    logic [DIM_W-1:0] width, height;
    logic cfg_ok, go, reject, hs, last_px, last_line;

    wbag_cfg_check #(
        .DIM_W(DIM_W), .MAX_LINES(MAX_LINES), .MAX_PIX_WIDE(MAX_PIX_WIDE)
    ) u_check (
        .base_lo(cfg_base[1:0]), .pitch_lo(cfg_pitch[3:0]), .dim(cfg_dim),
        .pix16(cfg_pix16), .width(width), .height(height), .cfg_ok(cfg_ok)
    );

    wbag_walker #(
        .ADDR_W(ADDR_W), .PITCH_W(PITCH_W), .DIM_W(DIM_W)
    ) u_walk (
        .clk(clk), .rst_n(rst_n), .load(go), .adv(hs),
        .base_word(cfg_base[ADDR_W-1:2]), .pitch_word(cfg_pitch[PITCH_W-1:2]),
        .width(width), .height(height), .pix16(cfg_pix16),
        .addr(req_addr), .strb(req_strb), .last_px(last_px),
        .last_line(last_line), .lines_done(lines_done)
    );

    always_comb begin
        go      = start && (state_q == ST_IDLE) && cfg_ok;
        reject  = start && (state_q == ST_IDLE) && !cfg_ok;
        hs      = req_valid && req_ready;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go) state_d = ST_EMIT;
            ST_EMIT: if (hs && last_px && last_line) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      err <= 1'b0;
        else if (go)     err <= 1'b0;
        else if (reject) err <= 1'b1;
    end

    always_comb begin
        req_valid = (state_q == ST_EMIT);
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
    end

    // R6: an offered request holds until taken
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=>
            (req_valid && $stable(req_addr) && $stable(req_strb)));

    // R2: a legal start leads to a request and a cleared line count
    p_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cfg_ok) |=> (req_valid && lines_done == '0));

    // R8: an illegal start raises the flag and emits nothing
    p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !cfg_ok) |=> (err && !req_valid && !busy));

    // R11: the completion pulse is followed by idle
    p_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
endmodule

// File: tb/wb_raster_agen_bench.sv
module wb_raster_agen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [15:0] cfg_pitch = '0;
    logic [31:0] cfg_dim = '0;
    logic        cfg_pix16 = 1'b0;
    logic        req_ready = 1'b0;
    logic        req_valid, busy, done, err;
    logic [31:0] req_addr;
    logic [3:0]  req_strb;
    logic [15:0] lines_done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    wb_raster_agen u_wb_raster_agen (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base),
        .cfg_pitch(cfg_pitch), .cfg_dim(cfg_dim), .cfg_pix16(cfg_pix16),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_strb(req_strb), .busy(busy), .done(done), .err(err),
        .lines_done(lines_done)
    );

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_addr(logic [31:0] b, int p, int x, int y, bit p16);
        logic [31:0] off;
        off = b + 32'(y * p) + 32'(x * (p16 ? 2 : 4));
        return {off[31:2], 2'b00};
    endfunction

    function automatic logic [3:0] ref_strb(logic [31:0] b, int p, int x, int y, bit p16);
        logic [31:0] off;
        off = b + 32'(y * p) + 32'(x * (p16 ? 2 : 4));
        if (!p16) return 4'b1111;
        return off[1] ? 4'b1100 : 4'b0011;
    endfunction

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    task automatic run_frame(logic [31:0] b, int p, int w, int h, bit p16, bit poke);
        int ex = 0, ey = 0, n = 0, exp_prog = 0;
        bit hold_pend = 0;
        logic [31:0] held_addr = '0;
        logic [3:0]  held_strb = '0;
        cfg_base = b; cfg_pitch = 16'(p); cfg_dim = {16'(h), 16'(w)};
        cfg_pix16 = p16; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 first request valid", req_valid, 1);
        chk("R7 count cleared at start", lines_done, 0);
        chk("R10 error cleared by legal start", err, 0);
        while (ey < h) begin
            if (poke && n == 3) begin
                start = 1'b1; cfg_base = b + 32'd64; cfg_pix16 = ~p16;
            end else begin
                start = 1'b0; cfg_base = b; cfg_pix16 = p16;
            end
            if (n > 0) chk("R7 line count", lines_done, exp_prog);
            chk("R3 request still valid", req_valid, 1);
            if (hold_pend) begin
                chk("R6 address held", req_addr, held_addr);
                chk("R6 strobe held", req_strb, held_strb);
            end
            req_ready = (($urandom % 4) != 0);
            if (req_ready) begin
                hold_pend = 0;
                if (p16) begin
                    chk("R5 address", req_addr, ref_addr(b, p, ex, ey, p16));
                    chk("R5 strobe", req_strb, ref_strb(b, p, ex, ey, p16));
                end else begin
                    chk("R4 address", req_addr, ref_addr(b, p, ex, ey, p16));
                    chk("R4 strobe", req_strb, ref_strb(b, p, ex, ey, p16));
                end
                ex++;
                if (ex == w) begin ex = 0; ey++; exp_prog++; end
            end else begin
                hold_pend = 1; held_addr = req_addr; held_strb = req_strb;
            end
            n++;
            @(negedge clk);
        end
        start = 1'b0; req_ready = 1'b0; cfg_base = b; cfg_pix16 = p16;
        chk("R11 done pulse", done, 1);
        chk("R7 final count equals height", lines_done, h);
        chk("R3 no request after last pixel", req_valid, 0);
        if (poke) chk("R12 start while busy ignored", lines_done, h);
        @(negedge clk);
        chk("R11 done is one cycle", done, 0);
        chk("R11 idle after done", busy, 0);
    endtask

    task automatic reject_start(string req, logic [31:0] b, int p, int w, int h, bit p16);
        logic [15:0] prev;
        prev = lines_done;
        cfg_base = b; cfg_pitch = 16'(p); cfg_dim = {16'(h), 16'(w)};
        cfg_pix16 = p16; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({req, " error set"}, err, 1);
        chk({req, " no request"}, req_valid, 0);
        chk({req, " count kept"}, lines_done, prev);
        @(negedge clk);
        chk({req, " stays idle"}, busy, 0);
        chk("R10 error sticky", err, 1);
    endtask

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        chk("R1 reset valid", req_valid, 0);
        chk("R1 reset busy", busy, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle valid", req_valid, 0);
        chk("R1 idle done", done, 0);
        chk("R1 idle err", err, 0);
        chk("R1 idle count", lines_done, 0);

        run_frame(32'h0000_1000, 16, 1, 1, 0, 0);
        run_frame(32'h0000_2004, 32, 3, 2, 1, 0);
        run_frame(32'h1000_0000, 64, 5, 4, 0, 1);
        reject_start("R8 misaligned base", 32'h0000_3002, 32, 2, 2, 0);
        run_frame(32'h0000_3000, 32, 2, 2, 0, 0);
        reject_start("R8 misaligned pitch", 32'h0000_3000, 40, 2, 2, 0);
        reject_start("R9 zero width", 32'h0000_3000, 32, 0, 2, 0);
        reject_start("R9 zero height", 32'h0000_3000, 32, 2, 0, 1);
        reject_start("R9 height over limit", 32'h0000_3000, 16, 1, 4089, 0);
        reject_start("R9 wide width over limit", 32'h0000_3000, 7696, 1921, 1, 0);
        reject_start("R9 narrow width over limit", 32'h0000_3000, 7696, 3841, 1, 1);
        run_frame(32'h0000_4000, 7680, 1920, 1, 0, 0);
        run_frame(32'h0000_8000, 7696, 1921, 1, 1, 0);
        run_frame(32'h0001_0000, 16, 1, 4088, 0, 0);

        for (int i = 0; i < 40; i++) begin
            int w, h, mb, p;
            bit p16;
            w = 1 + int'($urandom % 6);
            h = 1 + int'($urandom % 4);
            p16 = bit'($urandom % 2);
            mb = w * (p16 ? 2 : 4);
            p = ((mb + 15) / 16) * 16 + 16 * int'($urandom % 3);
            run_frame($urandom & 32'hFFFF_FFFC, p, w, h, p16, (i % 5) == 0);
        end

        summary();
        $finish;
    end
endmodule